// File: doc/BRIEF.md
# Power Island Turn-On Sequencer

This block switches one gated power island on and off. A power-on request closes the island's power switches with the lowest inrush current limit. It then waits for the supply to report good. If the supply is not good within the window, the limit is raised one step and the wait starts again. Once the supply is good, the block releases electrical isolation and runs a memory repair handshake. Functional isolation is released last. A power-off request undoes these steps in reverse order, one per cycle.

The control outputs are packed into one word whose bit positions match the island's control register, so the switch, isolation and repair logic beside the block can decode it directly. The power-good and repair-complete indications come in as separate status pins. Each sequence ends with a one-cycle completion pulse carrying a result code. Each timeout window is sized from a parameter giving clock cycles per microsecond.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset, `ctrl_o` is all zero, `done_o` is 0 and `err_o` is 0. In `ctrl_o`, bit 0 closes the switches, bit 2 releases electrical isolation, bit 3 requests repair, bit 5 releases functional isolation and bits 14:13 hold the inrush code. All other bits are always 0.
- R2: If bit 0 is already set when an on request arrives in idle, `done_o` rises on the next cycle with `err_o`=0, and `ctrl_o` is unchanged.
- R3: An on request while the island is off sets bit 0 with inrush code 0 on the next cycle, with bits 2, 3 and 5 still clear.
- R4: While waiting for `pwr_ok_i`, each inrush code is held for 3*CYC_PER_US+1 cycles. The code then steps up by exactly one, and it never goes past 3. Codes 0..3 stand for 3.5, 5, 10 and 20 mA.
- R5: If `pwr_ok_i` is not seen with code 3, bit 0 and the inrush field are cleared. The sequence ends with `err_o`=1.
- R6: Once power is good, bit 2 is set first. Bit 3 is set on a later cycle. `rep_done_i` is then awaited for up to CYC_PER_US+1 cycles.
- R7: On a repair timeout, bits 3 and 2 are cleared first. Bit 0 and the inrush field are cleared on the following cycle, and the sequence ends with `err_o`=2.
- R8: When repair completes, bit 5 is set and bit 3 is cleared in the completion cycle. Bit 5 is never set earlier. `err_o` is 0 and the final inrush code is kept.
- R9: An off request clears bit 5, then bit 2, then bit 0 together with the inrush field, on three consecutive cycles. The third cycle also pulses `done_o` with `err_o`=0.
- R10: `done_o` is high for exactly one cycle per sequence, and `err_o` is 0 whenever `done_o` is low.
- R11: Requests that arrive while a sequence is running are ignored. If on and off are requested together in idle, the on request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_req_i | input | 1 | Power-on request, sampled in idle |
| off_req_i | input | 1 | Power-off request, sampled in idle |
| pwr_ok_i | input | 1 | Power-good status from the switch network |
| rep_done_i | input | 1 | Memory repair complete |
| ctrl_o | output | 15 | Packed island control word |
| done_o | output | 1 | One-cycle sequence completion pulse |
| err_o | output | 2 | Result code: 0 ok, 1 power-good timeout, 2 repair timeout |

## Verification
A wrong state register or a wrong escalation step shows at the ports as an isolation or repair bit out of order in `ctrl_o`, in the very cycle of the bad transition. A counter that reloads wrongly shows as a wrong number of cycles spent at inrush code 0, or as a failure code where the responders would have answered in time. A busy flag that fails to block a request shows as a second completion pulse, or as the island being powered off during a power-on sequence, within a few cycles of the end of that sequence.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int CTRL_W   = 15;
  localparam int B_SW     = 0;
  localparam int B_ISO_E  = 2;
  localparam int B_REP    = 3;
  localparam int B_ISO_F  = 5;
  localparam int B_INR_LO = 13;

  typedef enum logic [2:0] {
    S_IDLE, S_PG_WAIT, S_REP_START, S_REP_WAIT, S_FAIL_PWR, S_OFF_ELEC, S_OFF_SW
  } state_e;

  typedef enum logic [1:0] {
    E_NONE   = 2'd0,
    E_PGOOD  = 2'd1,
    E_REPAIR = 2'd2
  } err_e;
endpackage

// File: rtl/pis_timer.sv
module pis_timer #(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4: an idle counter must not wrap back to a nonzero value
  p_hold_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/pis_fsm.sv
module pis_fsm import pis_pkg::*; #(
  parameter int PG_CYC  = 750,
  parameter int REP_CYC = 250,
  parameter int TW      = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          on_req_i,
  input  logic          off_req_i,
  input  logic          pwr_ok_i,
  input  logic          rep_done_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          sw_on_o,
  output logic [1:0]    inrush_o,
  output logic          iso_e_rel_o,
  output logic          rep_req_o,
  output logic          iso_f_rel_o,
  output logic          done_o,
  output logic [1:0]    err_o
);
  state_e     state_q;
  logic       sw_on_q, iso_e_q, rep_q, iso_f_q, done_q;
  logic [1:0] inrush_q;
  err_e       err_q;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = TW'(PG_CYC);
    case (state_q)
      S_IDLE:      tmr_load_o = on_req_i && !sw_on_q;
      S_PG_WAIT:   tmr_load_o = !pwr_ok_i && tmr_zero_i && (inrush_q != 2'd3);
      S_REP_START: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(REP_CYC);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      sw_on_q  <= 1'b0;
      inrush_q <= 2'd0;
      iso_e_q  <= 1'b0;
      rep_q    <= 1'b0;
      iso_f_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= E_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= E_NONE;
      case (state_q)
        S_IDLE: begin
          if (on_req_i) begin
            if (sw_on_q) begin
              done_q <= 1'b1;
            end else begin
              sw_on_q  <= 1'b1;
              inrush_q <= 2'd0;
              state_q  <= S_PG_WAIT;
            end
          end else if (off_req_i) begin
            iso_f_q <= 1'b0;
            state_q <= S_OFF_ELEC;
          end
        end
        S_PG_WAIT: begin
          if (pwr_ok_i) begin
            iso_e_q <= 1'b1;
            state_q <= S_REP_START;
          end else if (tmr_zero_i) begin
            if (inrush_q == 2'd3) begin
              sw_on_q  <= 1'b0;
              inrush_q <= 2'd0;
              done_q   <= 1'b1;
              err_q    <= E_PGOOD;
              state_q  <= S_IDLE;
            end else begin
              inrush_q <= inrush_q + 2'd1;
            end
          end
        end
        S_REP_START: begin
          rep_q   <= 1'b1;
          state_q <= S_REP_WAIT;
        end
        S_REP_WAIT: begin
          if (rep_done_i) begin
            rep_q   <= 1'b0;
            iso_f_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (tmr_zero_i) begin
            rep_q   <= 1'b0;
            iso_e_q <= 1'b0;
            state_q <= S_FAIL_PWR;
          end
        end
        S_FAIL_PWR: begin
          sw_on_q  <= 1'b0;
          inrush_q <= 2'd0;
          done_q   <= 1'b1;
          err_q    <= E_REPAIR;
          state_q  <= S_IDLE;
        end
        S_OFF_ELEC: begin
          iso_e_q <= 1'b0;
          state_q <= S_OFF_SW;
        end
        S_OFF_SW: begin
          sw_on_q  <= 1'b0;
          inrush_q <= 2'd0;
          rep_q    <= 1'b0;
          done_q   <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign sw_on_o     = sw_on_q;
  assign inrush_o    = inrush_q;
  assign iso_e_rel_o = iso_e_q;
  assign rep_req_o   = rep_q;
  assign iso_f_rel_o = iso_f_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (err_o == 2'd0));
  p_inrush_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PG_WAIT && $past(state_q) == S_PG_WAIT && inrush_q != $past(inrush_q))
      |-> (inrush_q == $past(inrush_q) + 2'd1));
  p_iso_e_needs_sw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_e_q |-> sw_on_q);
  p_rep_needs_iso_e_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_q |-> iso_e_q);
  p_iso_f_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_f_q |-> (iso_e_q && sw_on_q && !rep_q));
  p_already_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && on_req_i && sw_on_q) |=> (done_o && sw_on_q && $stable(inrush_q)));
  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PG_WAIT && !pwr_ok_i && !tmr_zero_i) |=> (state_q == S_PG_WAIT));
  p_off_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_OFF_ELEC) |-> (!iso_f_q && sw_on_q == $past(sw_on_q)));
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq import pis_pkg::*; #(
  parameter int CYC_PER_US = 250,
  parameter int PG_US      = 3,
  parameter int REP_US     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              on_req_i,
  input  logic              off_req_i,
  input  logic              pwr_ok_i,
  input  logic              rep_done_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              done_o,
  output logic [1:0]        err_o
);
  localparam int PG_CYC  = PG_US * CYC_PER_US;
  localparam int REP_CYC = REP_US * CYC_PER_US;
  localparam int MAX_CYC = (PG_CYC > REP_CYC) ? PG_CYC : REP_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          sw_on, iso_e, rep_req, iso_f;
  logic [1:0]    inrush;

  pis_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  pis_fsm #(.PG_CYC(PG_CYC), .REP_CYC(REP_CYC), .TW(TW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .on_req_i    (on_req_i),
    .off_req_i   (off_req_i),
    .pwr_ok_i    (pwr_ok_i),
    .rep_done_i  (rep_done_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .sw_on_o     (sw_on),
    .inrush_o    (inrush),
    .iso_e_rel_o (iso_e),
    .rep_req_o   (rep_req),
    .iso_f_rel_o (iso_f),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  always_comb begin
    ctrl_o               = '0;
    ctrl_o[B_SW]         = sw_on;
    ctrl_o[B_ISO_E]      = iso_e;
    ctrl_o[B_REP]        = rep_req;
    ctrl_o[B_ISO_F]      = iso_f;
    ctrl_o[B_INR_LO+:2]  = inrush;
  end

  p_inrush_only_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[B_SW] |-> (ctrl_o[B_INR_LO+:2] == 2'd0));
endmodule

// File: tb/pwr_island_seq_bench.sv
`timescale 1ns/1ps
module pwr_island_seq_bench;
  localparam int CPU    = 250;
  localparam int PG_CYC = 3 * CPU;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        on_req = 1'b0, off_req = 1'b0;
  logic        pwr_ok, rep_done;
  logic [14:0] ctrl_o;
  logic        done_o;
  logic [1:0]  err_o;

  int errors = 0, checks = 0;
  int pg_thr = 0, pg_dly = 1, rep_dly = 1, pg_cnt = 0, rep_cnt = 0;
  bit rep_ok_c = 1'b1;
  bit on_exp = 1'b0;
  int cur_inr = 0;

  always #2 clk = ~clk;

  pwr_island_seq #(.CYC_PER_US(CPU)) u_pwr_island_seq (
    .clk_i(clk), .rst_ni(rst_n), .on_req_i(on_req), .off_req_i(off_req),
    .pwr_ok_i(pwr_ok), .rep_done_i(rep_done),
    .ctrl_o(ctrl_o), .done_o(done_o), .err_o(err_o)
  );

  // switch network and repair engine responders
  always @(posedge clk) begin
    if (ctrl_o[0] && int'(ctrl_o[14:13]) >= pg_thr) begin
      if (pg_cnt < pg_dly) pg_cnt <= pg_cnt + 1;
    end else pg_cnt <= 0;
    if (ctrl_o[3] && rep_ok_c) begin
      if (rep_cnt < rep_dly) rep_cnt <= rep_cnt + 1;
    end else rep_cnt <= 0;
  end
  assign pwr_ok   = ctrl_o[0] && (int'(ctrl_o[14:13]) >= pg_thr) && (pg_cnt >= pg_dly);
  assign rep_done = ctrl_o[3] && rep_ok_c && (rep_cnt >= rep_dly);

  function automatic logic [14:0] exp_word(bit on, int inr);
    logic [14:0] w = '0;
    if (on) begin
      w[0] = 1'b1; w[2] = 1'b1; w[5] = 1'b1; w[14:13] = inr[1:0];
    end
    return w;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_on(int thr, bit rep_ok, bit inject, bit both);
    logic [14:0] prev;
    int n = 0, lvl0 = 0, maxi = 0, extra = 0, exp_err;
    bit order_ok = 1'b1;
    bit was_on = on_exp;
    pg_thr = thr; rep_ok_c = rep_ok;
    pg_dly = 1 + $urandom_range(0, 39);
    rep_dly = 1 + $urandom_range(0, 39);
    prev = ctrl_o;
    on_req = 1'b1; off_req = both;
    @(negedge clk);
    on_req = 1'b0; off_req = 1'b0;
    if (!was_on)
      check(ctrl_o[0] && ctrl_o[14:13] == 2'd0 && ctrl_o[2] == 1'b0 && ctrl_o[5] == 1'b0,
            "R3 first write", ctrl_o, 15'h0001);
    while (!done_o && n < 6000) begin
      if (ctrl_o[0] && ctrl_o[14:13] == 2'd0) lvl0++;
      if (int'(ctrl_o[14:13]) > maxi) maxi = int'(ctrl_o[14:13]);
      if (ctrl_o[2] && !prev[2] && ctrl_o[3]) order_ok = 1'b0;
      if (ctrl_o[3] && !prev[3] && !prev[2]) order_ok = 1'b0;
      if (ctrl_o[5]) order_ok = 1'b0;
      prev = ctrl_o;
      if (inject && n == 2) begin off_req = 1'b1; on_req = 1'b1; end
      else begin off_req = 1'b0; on_req = 1'b0; end
      @(negedge clk);
      n++;
    end
    on_req = 1'b0; off_req = 1'b0;
    check(done_o, "R10 done seen", done_o, 1);
    if (was_on) begin
      check(n == 0, "R2 immediate done", n, 0);
      check(err_o == 2'd0 && ctrl_o == exp_word(1, cur_inr), "R2 untouched", ctrl_o, exp_word(1, cur_inr));
    end else if (thr > 3) begin
      exp_err = 1;
      check(err_o == 2'(exp_err), "R5 err code", err_o, exp_err);
      check(ctrl_o == 15'h0, "R5 word cleared", ctrl_o, 0);
      check(lvl0 == PG_CYC + 1, "R4 window length", lvl0, PG_CYC + 1);
      check(maxi == 3, "R4 top code", maxi, 3);
      on_exp = 1'b0; cur_inr = 0;
    end else if (!rep_ok) begin
      exp_err = 2;
      check(err_o == 2'(exp_err), "R7 err code", err_o, exp_err);
      check(ctrl_o == 15'h0, "R7 word cleared", ctrl_o, 0);
      check(prev[0] && !prev[2] && !prev[3], "R7 isolation first", prev, 15'h0001);
      check(order_ok, "R6 order", order_ok, 1);
      on_exp = 1'b0; cur_inr = 0;
    end else begin
      check(err_o == 2'd0, "R8 err code", err_o, 0);
      check(ctrl_o == exp_word(1, thr), "R8 final word", ctrl_o, exp_word(1, thr));
      check(order_ok, "R6 order", order_ok, 1);
      check(maxi == thr, "R4 escalation", maxi, thr);
      on_exp = 1'b1; cur_inr = thr;
    end
    @(negedge clk);
    check(!done_o && err_o == 2'd0, "R10 pulse width", {done_o, err_o}, 0);
    repeat (4) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check(extra == 0 && ctrl_o == exp_word(on_exp, cur_inr), "R11 busy requests ignored",
          ctrl_o, exp_word(on_exp, cur_inr));
  endtask

  task automatic run_off();
    off_req = 1'b1;
    @(negedge clk);
    off_req = 1'b0;
    check(!ctrl_o[5] && ctrl_o[2] == on_exp && ctrl_o[0] == on_exp && !done_o,
          "R9 step1", ctrl_o, on_exp ? 15'h0005 : 0);
    @(negedge clk);
    check(!ctrl_o[2] && ctrl_o[0] == on_exp && !done_o, "R9 step2", ctrl_o, on_exp ? 15'h0001 : 0);
    @(negedge clk);
    check(ctrl_o == 15'h0 && done_o && err_o == 2'd0, "R9 step3", {done_o, err_o, ctrl_o}, 18'h20000);
    @(negedge clk);
    check(!done_o, "R10 off pulse", done_o, 0);
    on_exp = 1'b0; cur_inr = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(ctrl_o == 15'h0 && !done_o && err_o == 2'd0, "R1 reset state", ctrl_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctrl_o == 15'h0 && !done_o, "R1 after release", ctrl_o, 0);
    // directed corners
    run_on(0, 1'b1, 1'b0, 1'b0);
    run_on(2, 1'b1, 1'b0, 1'b0);   // R2 already on
    run_off();
    run_on(4, 1'b1, 1'b0, 1'b0);   // R5 all codes time out
    run_on(3, 1'b0, 1'b0, 1'b0);   // R7 repair timeout
    run_on(1, 1'b1, 1'b1, 1'b1);   // R11 priority and busy injection
    run_off();
    run_off();                     // off while already off
    for (int i = 0; i < 24; i++) begin
      if (on_exp && $urandom_range(0, 9) < 3) run_on(0, 1'b1, 1'b0, 1'b0);
      else if (on_exp) run_off();
      else run_on($urandom_range(0, 4), $urandom_range(0, 3) != 0,
                  $urandom_range(0, 1), $urandom_range(0, 1));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule